// File: doc/BRIEF.md
# Indirect Register Port with Status and Interrupt Logic

This block is the host-visible register file of a network controller. The host never addresses registers directly. Instead it loads an 8-bit index into a pointer register, then reads or writes through one of two data windows. One window reaches the control/status space and the other reaches the configuration space, and both windows use the same pointer. The byte offsets of the pointer and of the configuration window depend on whether the host uses word-wide or double-word-wide I/O. The data window sits at the same offset in both modes.

Status index 0 holds the error flags. These are a collision error, a missed frame and a memory error. Each flag is set by a hardware event pulse and cleared by the host writing a 1 to its bit. Bit 15 of the same register is a read-only summary that reports whether any flag is set. The interrupt output combines a global enable with per-cause mask bits held at status index 3, and the collision error can never interrupt. A saturating counter of missed frames can be read at status index 112.

A watcher arms when a transmission ends. If the collision input stays low for a full window of bit times, the collision-error flag is raised. The watcher is disabled in full-duplex mode and while the stop bit is set. All data ports are plain, single-cycle register accesses, and reads return data combinationally in the same cycle as the access.

Top module: `nic_regport`

## Requirements
- R1: A write at offset 12h (word mode, `dword_mode`=0) or 14h (double-word mode) loads the pointer from `io_wdata[7:0]`. A read at that offset returns the pointer in bits 7:0, with every higher bit returned as zero.
- R2: Offset 10h accesses the status space and the configuration window (16h in word mode, 1Ch in double-word mode) accesses the configuration space. Both are indexed by the same pointer. Configuration indices below `NUM_CFG` are 16-bit read/write registers that reset to zero.
- R3: The pointer is cleared by `rst_n` low and by a `soft_rst` pulse. It changes only on a pointer write or a reset.
- R4: In status register 0, the collision-error (bit 13), missed-frame (bit 12) and memory-error (bit 11) flags clear when 1 is written to their bit. Writing 0 leaves them unchanged, so writing back a value just read clears every flag that was set.
- R5: Status bit 15 reads 1 whenever any of bits 13, 12 or 11 is set. Writes to bit 15 are ignored.
- R6: A `miss_evt` pulse sets bit 12 and increments the 16-bit counter at status index 112. The counter saturates at FFFFh and is cleared by either reset.
- R7: `irq` is 1 exactly when the enable (status bit 6) is 1 and at least one of these holds: bit 12 is set while mask bit 12 of status index 3 is 0, or bit 11 is set while mask bit 11 of status index 3 is 0. The collision error never drives `irq`.
- R8: In half duplex, a `tx_done` pulse arms a window of `COL_WINDOW` cycles. If `col_in` is not seen high during that window, bit 13 sets. With `full_duplex` high, no collision error is ever raised.
- R9: If a flag's hardware event and a host write of 1 to that flag occur in the same cycle, the flag ends up set.
- R10: Writing 1 to the stop bit (status bit 2) clears bit 13 and holds it clear while stop is 1. The pointer and the other flags are unaffected by stop.
- R11: Reads of undefined status indices, and of configuration indices at or above `NUM_CFG`, return zero. Writes to them change no defined register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset pulse |
| dword_mode | input | 1 | 0: word I/O offsets, 1: double-word I/O offsets |
| io_en | input | 1 | Host access strobe, one cycle per access |
| io_we | input | 1 | 1 write, 0 read |
| io_addr | input | 5 | Byte offset of the access |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid in the cycle of a read access |
| miss_evt | input | 1 | Frame arrived with no receive descriptor |
| mem_err_evt | input | 1 | Memory error event |
| tx_done | input | 1 | Pulse at end of a transmission |
| col_in | input | 1 | Collision indication from the line side |
| full_duplex | input | 1 | Link runs full duplex |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these properties:
- The interrupt stays low while the enable is off.
- A hardware event always leaves its flag set on the next cycle.
- No collision error appears in full duplex or while stop is set.
- The pointer moves only on a pointer write or a reset.
- The missed-frame count never decreases except on a software reset.

The scenarios are needed for what cycle-local properties cannot show:
- the offset map in both I/O modes;
- the write-one-to-clear and read-back-to-clear behaviour;
- the window length of the collision check and how a collision inside the window cancels it;
- mask combinations on the interrupt;
- isolation of undefined indices;
- counter saturation after 65535 events.

// File: rtl/nic_regport_pkg.sv
package nic_regport_pkg;
  typedef enum logic [1:0] {PORT_NONE, PORT_STAT, PORT_PTR, PORT_CFG} port_e;

  localparam logic [4:0] OFS_DATA    = 5'h10;
  localparam logic [4:0] OFS_PTR_WD  = 5'h12;
  localparam logic [4:0] OFS_PTR_DW  = 5'h14;
  localparam logic [4:0] OFS_CFG_WD  = 5'h16;
  localparam logic [4:0] OFS_CFG_DW  = 5'h1C;

  localparam logic [7:0] IDX_STATUS  = 8'd0;
  localparam logic [7:0] IDX_MASK    = 8'd3;
  localparam logic [7:0] IDX_MISSCNT = 8'd112;

  localparam int B_ERR   = 15;
  localparam int B_CERR  = 13;
  localparam int B_MISS  = 12;
  localparam int B_MERR  = 11;
  localparam int B_IENA  = 6;
  localparam int B_STOP  = 2;
endpackage

// File: rtl/nic_regport_decode.sv
module nic_regport_decode
  import nic_regport_pkg::*;
(
  input  logic       en,
  input  logic       we,
  input  logic       dword_mode,
  input  logic [4:0] addr,
  output port_e      sel,
  output logic       wr
);
  logic [4:0] ptr_ofs;
  logic [4:0] cfg_ofs;

  always_comb begin
    ptr_ofs = dword_mode ? OFS_PTR_DW : OFS_PTR_WD;
    cfg_ofs = dword_mode ? OFS_CFG_DW : OFS_CFG_WD;
    sel     = PORT_NONE;
    if (en) begin
      if (addr == OFS_DATA)     sel = PORT_STAT;
      else if (addr == ptr_ofs) sel = PORT_PTR;
      else if (addr == cfg_ofs) sel = PORT_CFG;
    end
    wr = en & we;
  end
endmodule

// File: rtl/nic_regport_colwatch.sv
module nic_regport_colwatch #(
  parameter int COL_WINDOW = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic enable,
  input  logic start,
  input  logic col,
  output logic fire
);
  localparam int CW = $clog2(COL_WINDOW + 1);

  logic          armed_q;
  logic [CW-1:0] left_q;

  assign fire = armed_q & enable & ~col & (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (clr || !enable) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (start) begin
      armed_q <= 1'b1;
      left_q  <= CW'(COL_WINDOW);
    end else if (armed_q) begin
      if (col || left_q == CW'(1)) armed_q <= 1'b0;
      left_q <= left_q - CW'(1);
    end
  end
endmodule

// File: rtl/nic_regport_satcnt.sv
module nic_regport_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != '1)   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/nic_regport.sv
module nic_regport
  import nic_regport_pkg::*;
#(
  parameter int NUM_CFG    = 8,
  parameter int CFG_W      = 16,
  parameter int CNT_W      = 16,
  parameter int COL_WINDOW = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        dword_mode,
  input  logic        io_en,
  input  logic        io_we,
  input  logic [4:0]  io_addr,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  input  logic        miss_evt,
  input  logic        mem_err_evt,
  input  logic        tx_done,
  input  logic        col_in,
  input  logic        full_duplex,
  output logic        irq
);
  port_e             sel;
  logic              wr;
  logic              ptr_we, stat_we, mask_we, cfg_we;
  logic [7:0]        ptr_q;
  logic              cerr_q, miss_q, merr_q, iena_q, stop_q;
  logic              msk_miss_q, msk_merr_q;
  logic              cerr_set, stop_now;
  logic [31:0]       clr_bits;
  logic [CNT_W-1:0]  miss_cnt;
  logic [CFG_W-1:0]  cfg_q [NUM_CFG];
  logic [CFG_W-1:0]  cfg_rd;
  logic [31:0]       stat_rd;
  logic              unused_hi;

  assign unused_hi = ^io_wdata[31:16];

  nic_regport_decode u_dec (
    .en(io_en), .we(io_we), .dword_mode(dword_mode), .addr(io_addr),
    .sel(sel), .wr(wr)
  );

  assign ptr_we  = wr && sel == PORT_PTR;
  assign stat_we = wr && sel == PORT_STAT && ptr_q == IDX_STATUS;
  assign mask_we = wr && sel == PORT_STAT && ptr_q == IDX_MASK;
  assign cfg_we  = wr && sel == PORT_CFG;

  assign clr_bits = stat_we ? io_wdata : 32'd0;
  assign stop_now = stat_we & io_wdata[B_STOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (soft_rst)  ptr_q <= '0;
    else if (ptr_we)    ptr_q <= io_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cerr_q <= 1'b0; miss_q <= 1'b0; merr_q <= 1'b0;
      iena_q <= 1'b0; stop_q <= 1'b0;
      msk_miss_q <= 1'b0; msk_merr_q <= 1'b0;
    end else if (soft_rst) begin
      cerr_q <= 1'b0; miss_q <= 1'b0; merr_q <= 1'b0;
      iena_q <= 1'b0; stop_q <= 1'b0;
      msk_miss_q <= 1'b0; msk_merr_q <= 1'b0;
    end else begin
      miss_q <= miss_evt    | (miss_q & ~clr_bits[B_MISS]);
      merr_q <= mem_err_evt | (merr_q & ~clr_bits[B_MERR]);
      if (stop_q || stop_now) cerr_q <= 1'b0;
      else                    cerr_q <= cerr_set | (cerr_q & ~clr_bits[B_CERR]);
      if (stat_we) begin
        iena_q <= io_wdata[B_IENA];
        stop_q <= io_wdata[B_STOP];
      end
      if (mask_we) begin
        msk_miss_q <= io_wdata[B_MISS];
        msk_merr_q <= io_wdata[B_MERR];
      end
    end
  end

  nic_regport_colwatch #(.COL_WINDOW(COL_WINDOW)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .enable(~full_duplex & ~stop_q), .start(tx_done), .col(col_in),
    .fire(cerr_set)
  );

  nic_regport_satcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .inc(miss_evt), .cnt(miss_cnt)
  );

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cfg_q[g] <= '0;
      else if (soft_rst)                      cfg_q[g] <= '0;
      else if (cfg_we && ptr_q == 8'(g))      cfg_q[g] <= io_wdata[CFG_W-1:0];
    end
  end

  always_comb begin
    cfg_rd = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (ptr_q == 8'(i)) cfg_rd = cfg_q[i];
  end

  always_comb begin
    stat_rd = 32'd0;
    case (ptr_q)
      IDX_STATUS: begin
        stat_rd[B_ERR]  = cerr_q | miss_q | merr_q;
        stat_rd[B_CERR] = cerr_q;
        stat_rd[B_MISS] = miss_q;
        stat_rd[B_MERR] = merr_q;
        stat_rd[B_IENA] = iena_q;
        stat_rd[B_STOP] = stop_q;
      end
      IDX_MASK: begin
        stat_rd[B_MISS] = msk_miss_q;
        stat_rd[B_MERR] = msk_merr_q;
      end
      IDX_MISSCNT: stat_rd = 32'(miss_cnt);
      default:     stat_rd = 32'd0;
    endcase
  end

  always_comb begin
    io_rdata = 32'd0;
    if (!io_we) begin
      case (sel)
        PORT_STAT: io_rdata = stat_rd;
        PORT_PTR:  io_rdata = {24'd0, ptr_q};
        PORT_CFG:  io_rdata = 32'(cfg_rd);
        default:   io_rdata = 32'd0;
      endcase
    end
  end

  assign irq = iena_q & ((miss_q & ~msk_miss_q) | (merr_q & ~msk_merr_q));
endmodule

// File: rtl/nic_regport_chk.sv
module nic_regport_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             full_duplex,
  input logic             irq,
  input logic             iena,
  input logic             miss_evt,
  input logic             miss,
  input logic             cerr,
  input logic             stop,
  input logic [7:0]       ptr,
  input logic             ptr_wr,
  input logic [CNT_W-1:0] cnt
);
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !iena |-> !irq);

  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && !soft_rst) |=> miss);

  a_r8_full_duplex_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |=> !$rose(cerr));

  a_r10_stop_holds_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !cerr);

  a_r3_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !soft_rst) |=> $stable(ptr));

  a_r6_count_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> cnt >= $past(cnt));
endmodule

bind nic_regport nic_regport_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .full_duplex(full_duplex),
  .irq(irq), .iena(iena_q), .miss_evt(miss_evt), .miss(miss_q),
  .cerr(cerr_q), .stop(stop_q), .ptr(ptr_q), .ptr_wr(ptr_we), .cnt(miss_cnt)
);

// File: tb/test_nic_regport.sv
module test_nic_regport;
  localparam int W = 20;
  localparam logic [4:0] D = 5'h10, P = 5'h12, C = 5'h16;

  logic        clk = 0, rst_n = 0, soft_rst = 0, dword_mode = 0;
  logic        io_en = 0, io_we = 0;
  logic [4:0]  io_addr = '0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic        miss_evt = 0, mem_err_evt = 0, tx_done = 0, col_in = 0, full_duplex = 0;
  logic        irq;
  int          checks = 0, fails = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  nic_regport #(.COL_WINDOW(W)) i_nic_regport (.*);

  always @(negedge clk) begin
    if (io_en && !io_we) begin
      item_t it;
      checks++;
      if (q.size() == 0) begin
        fails++; $display("FAIL monitor: read with empty queue, got %h", io_rdata);
      end else begin
        it = q.pop_front();
        if (io_rdata !== it.exp) begin
          fails++; $display("FAIL %s: rdata=%h expected=%h", it.tag, io_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1 io_en = 1; io_we = 1; io_addr = a; io_wdata = d;
    @(posedge clk); #1 io_en = 0; io_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1 q.push_back(it); io_en = 1; io_we = 0; io_addr = a;
    @(posedge clk); #1 io_en = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin fails++; $display("FAIL %s: irq=%b expected=%b", tag, irq, e); end
  endtask

  task automatic pulse_miss();
    @(posedge clk); #1 miss_evt = 1; @(posedge clk); #1 miss_evt = 0;
  endtask
  task automatic pulse_merr();
    @(posedge clk); #1 mem_err_evt = 1; @(posedge clk); #1 mem_err_evt = 0;
  endtask
  task automatic pulse_tx();
    @(posedge clk); #1 tx_done = 1; @(posedge clk); #1 tx_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // reset state (R3)
    rd(P, 0, "R3 reset pointer"); rd(D, 0, "R4 reset status"); chk_irq(0, "R7 reset");
    // R1 pointer port
    wr(P, 32'h0000AB05); rd(P, 32'h5, "R1 pointer upper zero");
    // R2 configuration window shares pointer
    wr(P, 1); wr(C, 32'h1234); rd(C, 32'h1234, "R2 cfg1");
    wr(P, 2); rd(C, 0, "R2 cfg2 untouched");
    dword_mode = 1;
    wr(5'h14, 1); rd(5'h14, 1, "R1 dword pointer"); rd(5'h1C, 32'h1234, "R2 dword cfg");
    rd(5'h16, 0, "R2 word cfg offset dead in dword");
    dword_mode = 0;
    // R6 / R5 / R4
    wr(P, 0); pulse_miss(); rd(D, 32'h9000, "R6 miss flag");
    wr(P, 112); rd(D, 1, "R6 count one"); wr(P, 0);
    wr(D, 32'h8000); rd(D, 32'h9000, "R5 err write ignored");
    wr(D, 0); rd(D, 32'h9000, "R4 write zero no effect");
    pulse_merr(); rd(D, 32'h9800, "R5 summary");
    wr(D, 32'h9800); rd(D, 0, "R4 readback clears");
    // R7 interrupt gating
    wr(D, 32'h40); pulse_miss(); chk_irq(1, "R7 miss unmasked");
    wr(P, 3); wr(D, 32'h1000); chk_irq(0, "R7 miss masked");
    rd(D, 32'h1000, "R7 mask readback");
    wr(P, 0); rd(D, 32'h9040, "R7 masked still sets err");
    pulse_merr(); chk_irq(1, "R7 merr unmasked");
    wr(D, 32'h0840); chk_irq(0, "R7 merr cleared");
    wr(P, 3); wr(D, 0); chk_irq(1, "R7 miss unmask");
    wr(P, 0); wr(D, 0); chk_irq(0, "R7 global enable off");
    wr(D, 32'h1000); rd(D, 0, "R4 clear miss");
    // R8 collision watch
    pulse_tx(); repeat (8) @(posedge clk); rd(D, 0, "R8 inside window");
    repeat (W) @(posedge clk); rd(D, 32'hA000, "R8 window expired");
    wr(D, 32'h40); chk_irq(0, "R7 cerr never interrupts");
    wr(D, 32'h2040); rd(D, 32'h40, "R4 cerr cleared");
    pulse_tx(); repeat (4) @(posedge clk);
    @(posedge clk); #1 col_in = 1; @(posedge clk); #1 col_in = 0;
    repeat (W + 5) @(posedge clk); rd(D, 32'h40, "R8 collision seen");
    full_duplex = 1; pulse_tx(); repeat (W + 5) @(posedge clk);
    rd(D, 32'h40, "R8 full duplex disabled"); full_duplex = 0;
    // R9 set beats clear
    pulse_miss();
    @(posedge clk); #1 io_en = 1; io_we = 1; io_addr = D; io_wdata = 32'h1040; miss_evt = 1;
    @(posedge clk); #1 io_en = 0; io_we = 0; miss_evt = 0;
    rd(D, 32'h9040, "R9 set wins");
    wr(D, 32'h1040); rd(D, 32'h40, "R9 later clear");
    // R10 stop
    pulse_tx(); repeat (W + 3) @(posedge clk); rd(D, 32'hA040, "R10 cerr before stop");
    wr(D, 32'h44); rd(D, 32'h44, "R10 stop clears cerr");
    rd(P, 0, "R10 pointer unchanged");
    pulse_miss(); rd(D, 32'h9044, "R10 miss during stop");
    pulse_tx(); repeat (W + 3) @(posedge clk); rd(D, 32'h9044, "R10 no cerr in stop");
    wr(D, 32'h1040); rd(D, 32'h40, "R10 leave stop");
    // R11 undefined indices
    wr(P, 8'h50); wr(D, 32'hFFFF); rd(D, 0, "R11 undefined status read");
    wr(P, 0); rd(D, 32'h40, "R11 status intact");
    wr(P, 9); wr(C, 32'hBEEF); rd(C, 0, "R11 undefined cfg read");
    wr(P, 1); rd(C, 32'h1234, "R11 cfg intact");
    // R3 software reset
    wr(P, 7); @(posedge clk); #1 soft_rst = 1; @(posedge clk); #1 soft_rst = 0;
    rd(P, 0, "R3 soft reset pointer"); rd(D, 0, "R3 soft reset status");
    // R6 saturation
    @(posedge clk); #1 miss_evt = 1; repeat (65540) @(posedge clk); #1 miss_evt = 0;
    wr(P, 112); rd(D, 32'hFFFF, "R6 saturated");
    pulse_miss(); rd(D, 32'hFFFF, "R6 stays saturated");
    repeat (3) @(posedge clk);
    if (q.size() != 0) begin
      fails++; $display("FAIL scoreboard: %0d reads unseen, expected 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule